// File: doc/BRIEF.md
# Control-Message Descriptor Ring Engine

This block is the device side of a pair of descriptor rings that carry control traffic between a host driver and on-chip firmware. The host writes commands into a transmit ring in shared memory. It then moves that ring's tail pointer forward. The engine reads each pending descriptor, carries out the optional buffer transfer, and writes back a status. It then moves the head pointer forward by one. The host knows a command is finished when the head it reads back equals the tail it wrote.

The receive ring works in the opposite direction. The host prepares empty descriptors, each optionally pointing at a buffer, and arms the ring by setting its tail. Events arrive on a valid/ready injection port. Each accepted event fills the descriptor at head and advances head. If no descriptor is free, the event is discarded and a sticky overflow flag is raised.

Each ring has five host registers: base low, base high, length (which includes an enable bit), head and tail. Descriptors are four 32-bit words, read and written over a single memory port with a fixed one-cycle read latency. Only one descriptor is processed at a time.

Top module: `acq_ring_engine`

## Requirements
- R1: After reset every register reads zero, `evt_ready` is 1, `mem_req` is 0 and `cmd_irq` and `rx_overflow` are 0.
- R2: Register map: `reg_addr[3]` selects the ring (0 transmit, 1 receive), and `reg_addr[2:0]` selects the register: 0 base low, 1 base high, 2 length, 3 head, 4 tail. The length register holds the enable in bit 31, the overflow flag in bit 30 (read-only) and the descriptor count in bits [8:0]. Host writes to head are ignored.
- R3: Head advances by exactly one per processed descriptor, wraps to 0 when it reaches the count, and always stays below the count.
- R4: While a ring is enabled and head differs from tail, the transmit descriptors are processed in ring order until head equals tail. Descriptor i sits at word address base + 4*i and has this layout: word0 = {opcode[31:16], flags[15:0]}, word1 = {retval[31:16], datalen[15:0]}, word2/word3 = buffer word address low/high.
- R5: Transmit write-back keeps the opcode and flags, and also sets done (flag bit 0) and complete (flag bit 1). Word1 receives a return value of 0 for success, with datalen kept. Both words are written before head moves.
- R6: When flag bit 12 (buffer present) is set, the command is indirect and the engine writes {opcode, datalen} to the first word of the buffer. When that flag is clear, the command is direct and the buffer address is neither read nor written.
- R7: An indirect command with datalen 0 completes with return value 1 and also sets the error flag (bit 2).
- R8: A transmit descriptor with flag bit 13 set produces a one-cycle `cmd_irq` pulse when it completes. Descriptors without that flag produce no pulse.
- R9: Several descriptors posted behind a single tail update are all processed.
- R10: An event is accepted when `evt_valid` and `evt_ready` are both high. On a ring with room, the descriptor at head is updated: word0 becomes {event opcode, flags with done and complete set}, and the large-buffer flag (bit 9) and datalen are kept. If flag bit 12 is set, `evt_data` goes to the first word of the buffer. Head then advances.
- R11: An event that finds the receive ring full (head equals tail) or disabled is dropped with no memory write. In that case `rx_overflow` and length bit 30 go to 1 and stay there until the host writes that length register.
- R12: Writing a length register with bit 31 clear forces that ring's head to 0 and stops processing, even if tail is nonzero.
- R13: A receive ring armed with tail = count-1 accepts exactly count-1 events before it overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 4 | Ring select and register index |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 64 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after a read request |
| evt_valid | input | 1 | Receive event offered |
| evt_ready | output | 1 | Engine can take an event this cycle |
| evt_opcode | input | 16 | Event opcode |
| evt_data | input | 32 | Event payload word |
| cmd_irq | output | 1 | Completion pulse for flagged commands |
| rx_overflow | output | 1 | Sticky receive-overflow flag |

## Verification
The assertions rely on the following host behaviour:
- The host changes a ring's count or base only while that ring is disabled or idle.
- The host writes only tail values below the count.
- The host uses a count of at least two.

The assertions also rely on the memory returning read data on the cycle after the request. The stimulus respects all of these conditions:
- The bench programs the configuration only when head equals tail.
- Every tail it writes is taken modulo the count.
- It rewrites descriptors and buffers only while the engine is idle.
- Its memory model answers reads with a fixed one-cycle latency.

// File: rtl/acq_pkg.sv
package acq_pkg;

    localparam int DESC_WORDS = 4;

    localparam int FL_DONE  = 0;
    localparam int FL_CMPL  = 1;
    localparam int FL_ERR   = 2;
    localparam int FL_LARGE = 9;
    localparam int FL_BUF   = 12;
    localparam int FL_IRQ   = 13;

    typedef enum logic [3:0] {
        ST_IDLE, ST_RD0, ST_RD1, ST_RD2, ST_RD3,
        ST_CAP, ST_BUF, ST_WB1, ST_WB0, ST_ADV
    } eng_state_e;

    typedef enum logic {
        RING_TX = 1'b0,
        RING_RX = 1'b1
    } ring_sel_e;

    typedef struct packed {
        logic [15:0] opcode;
        logic [15:0] flags;
        logic [15:0] datalen;
        logic [63:0] buf_addr;
    } desc_t;

    function automatic logic [15:0] wb_flags(input logic [15:0] fl, input logic err);
        logic [15:0] r;
        r = fl;
        r[FL_DONE] = 1'b1;
        r[FL_CMPL] = 1'b1;
        if (err) r[FL_ERR] = 1'b1;
        return r;
    endfunction

    function automatic logic [15:0] ret_code(input logic err);
        return err ? 16'd1 : 16'd0;
    endfunction

endpackage

// File: rtl/acq_ring_regs.sv
module acq_ring_regs #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_base_lo,
    input  logic             wr_base_hi,
    input  logic             wr_len,
    input  logic             wr_tail,
    input  logic [31:0]      wdata,
    input  logic             adv,
    input  logic             set_ovf,
    output logic [63:0]      base,
    output logic [CNT_W-1:0] count,
    output logic             en,
    output logic [CNT_W-1:0] head,
    output logic [CNT_W-1:0] tail,
    output logic             ovf,
    output logic             pending
);

    logic [CNT_W-1:0] head_inc;

    assign head_inc = head + 1'b1;
    assign pending  = en && (head != tail);

    always_ff @(posedge clk) begin
        if (rst) begin
            base  <= '0;
            count <= '0;
            en    <= 1'b0;
            head  <= '0;
            tail  <= '0;
            ovf   <= 1'b0;
        end else begin
            if (wr_base_lo) base[31:0]  <= wdata;
            if (wr_base_hi) base[63:32] <= wdata;
            if (wr_tail)    tail        <= wdata[CNT_W-1:0];
            if (wr_len) begin
                en    <= wdata[31];
                count <= wdata[CNT_W-1:0];
            end
            if (wr_len && !wdata[31])
                head <= '0;
            else if (adv && en)
                head <= (head_inc == count) ? '0 : head_inc;
            if (wr_len)
                ovf <= 1'b0;
            else if (set_ovf)
                ovf <= 1'b1;
        end
    end

    // R3: head index stays inside the ring
    a_r3_head_in_range: assert property (@(posedge clk) disable iff (rst)
        (en && count != '0) |-> (head < count));

    // R3: head moves by one step or returns to zero
    a_r3_head_step: assert property (@(posedge clk) disable iff (rst)
        (head != $past(head)) |-> (head == '0 || head == $past(head) + 1'b1));

    // R11: overflow flag holds until the length register is written
    a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf && !wr_len) |=> ovf);

endmodule

// File: rtl/acq_cmd_engine.sv
module acq_cmd_engine
    import acq_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_pending,
    input  logic [63:0]      tx_base,
    input  logic [CNT_W-1:0] tx_head,
    input  logic             rx_room,
    input  logic [63:0]      rx_base,
    input  logic [CNT_W-1:0] rx_head,
    input  logic             evt_valid,
    input  logic [15:0]      evt_opcode,
    input  logic [31:0]      evt_data,
    output logic             evt_ready,
    output logic             rx_drop,
    output logic             tx_adv,
    output logic             rx_adv,
    output logic             cmd_irq,
    output logic             mem_req,
    output logic             mem_we,
    output logic [63:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic [31:0]      mem_rdata
);

    localparam logic [63:0] WORD_STEP = 64'(DESC_WORDS);

    eng_state_e  state;
    ring_sel_e   sel;
    logic [63:0] daddr;
    desc_t       desc;
    logic [15:0] ev_op_q;
    logic [31:0] ev_data_q;
    logic        cmd_err;
    logic [15:0] op_out;

    assign cmd_err = (sel == RING_TX) && desc.flags[FL_BUF] && (desc.datalen == 16'd0);
    assign op_out  = (sel == RING_RX) ? ev_op_q : desc.opcode;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            sel       <= RING_TX;
            daddr     <= '0;
            desc      <= '0;
            ev_op_q   <= '0;
            ev_data_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (tx_pending) begin
                        sel   <= RING_TX;
                        daddr <= tx_base + 64'(tx_head) * WORD_STEP;
                        state <= ST_RD0;
                    end else if (evt_valid && rx_room) begin
                        sel       <= RING_RX;
                        daddr     <= rx_base + 64'(rx_head) * WORD_STEP;
                        ev_op_q   <= evt_opcode;
                        ev_data_q <= evt_data;
                        state     <= ST_RD0;
                    end
                end
                ST_RD0: state <= ST_RD1;
                ST_RD1: begin
                    desc.opcode <= mem_rdata[31:16];
                    desc.flags  <= mem_rdata[15:0];
                    state       <= ST_RD2;
                end
                ST_RD2: begin
                    desc.datalen <= mem_rdata[15:0];
                    state        <= ST_RD3;
                end
                ST_RD3: begin
                    desc.buf_addr[31:0] <= mem_rdata;
                    state               <= ST_CAP;
                end
                ST_CAP: begin
                    desc.buf_addr[63:32] <= mem_rdata;
                    state                <= ST_BUF;
                end
                ST_BUF: state <= ST_WB1;
                ST_WB1: state <= ST_WB0;
                ST_WB0: state <= ST_ADV;
                ST_ADV: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        evt_ready = 1'b0;
        rx_drop   = 1'b0;
        tx_adv    = 1'b0;
        rx_adv    = 1'b0;
        cmd_irq   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                evt_ready = !tx_pending;
                rx_drop   = !tx_pending && evt_valid && !rx_room;
            end
            ST_RD0: begin
                mem_req  = 1'b1;
                mem_addr = daddr;
            end
            ST_RD1: begin
                mem_req  = 1'b1;
                mem_addr = daddr + 64'd1;
            end
            ST_RD2: begin
                mem_req  = 1'b1;
                mem_addr = daddr + 64'd2;
            end
            ST_RD3: begin
                mem_req  = 1'b1;
                mem_addr = daddr + 64'd3;
            end
            ST_BUF: begin
                if (desc.flags[FL_BUF]) begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = desc.buf_addr;
                    mem_wdata = (sel == RING_TX) ? {desc.opcode, desc.datalen} : ev_data_q;
                end
            end
            ST_WB1: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = daddr + 64'd1;
                mem_wdata = {ret_code(cmd_err), desc.datalen};
            end
            ST_WB0: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = daddr;
                mem_wdata = {op_out, wb_flags(desc.flags, cmd_err)};
            end
            ST_ADV: begin
                tx_adv  = (sel == RING_TX);
                rx_adv  = (sel == RING_RX);
                cmd_irq = (sel == RING_TX) && desc.flags[FL_IRQ];
            end
            default: ;
        endcase
    end

    // R8: completion pulse only right after a descriptor write-back
    a_r8_irq_after_wb: assert property (@(posedge clk) disable iff (rst)
        cmd_irq |-> $past(mem_we));

    // R11: a dropped event never coincides with a memory access
    a_r11_drop_quiet: assert property (@(posedge clk) disable iff (rst)
        rx_drop |-> !mem_req);

endmodule

// File: rtl/acq_ring_engine.sv
module acq_ring_engine
    import acq_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [63:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        evt_valid,
    output logic        evt_ready,
    input  logic [15:0] evt_opcode,
    input  logic [31:0] evt_data,
    output logic        cmd_irq,
    output logic        rx_overflow
);

    localparam int NRING = 2;

    logic [63:0]      r_base  [NRING];
    logic [CNT_W-1:0] r_count [NRING];
    logic [CNT_W-1:0] r_head  [NRING];
    logic [CNT_W-1:0] r_tail  [NRING];
    logic [NRING-1:0] r_en, r_ovf, r_pend, r_adv, r_setovf;
    logic             tx_adv, rx_adv, rx_drop;

    assign r_adv    = {rx_adv, tx_adv};
    assign r_setovf = {rx_drop, 1'b0};

    for (genvar g = 0; g < NRING; g++) begin : g_ring
        logic sel_ring;
        assign sel_ring = reg_wr && (reg_addr[3] == g[0]);
        acq_ring_regs #(.CNT_W(CNT_W)) u_ring (
            .clk        (clk),
            .rst        (rst),
            .wr_base_lo (sel_ring && reg_addr[2:0] == 3'd0),
            .wr_base_hi (sel_ring && reg_addr[2:0] == 3'd1),
            .wr_len     (sel_ring && reg_addr[2:0] == 3'd2),
            .wr_tail    (sel_ring && reg_addr[2:0] == 3'd4),
            .wdata      (reg_wdata),
            .adv        (r_adv[g]),
            .set_ovf    (r_setovf[g]),
            .base       (r_base[g]),
            .count      (r_count[g]),
            .en         (r_en[g]),
            .head       (r_head[g]),
            .tail       (r_tail[g]),
            .ovf        (r_ovf[g]),
            .pending    (r_pend[g])
        );
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr[2:0])
            3'd0: reg_rdata = r_base[reg_addr[3]][31:0];
            3'd1: reg_rdata = r_base[reg_addr[3]][63:32];
            3'd2: begin
                reg_rdata[31]          = r_en[reg_addr[3]];
                reg_rdata[30]          = r_ovf[reg_addr[3]];
                reg_rdata[CNT_W-1:0]   = r_count[reg_addr[3]];
            end
            3'd3: reg_rdata[CNT_W-1:0] = r_head[reg_addr[3]];
            3'd4: reg_rdata[CNT_W-1:0] = r_tail[reg_addr[3]];
            default: ;
        endcase
    end

    assign rx_overflow = r_ovf[1];

    acq_cmd_engine #(.CNT_W(CNT_W)) u_eng (
        .clk        (clk),
        .rst        (rst),
        .tx_pending (r_pend[0]),
        .tx_base    (r_base[0]),
        .tx_head    (r_head[0]),
        .rx_room    (r_pend[1]),
        .rx_base    (r_base[1]),
        .rx_head    (r_head[1]),
        .evt_valid  (evt_valid),
        .evt_opcode (evt_opcode),
        .evt_data   (evt_data),
        .evt_ready  (evt_ready),
        .rx_drop    (rx_drop),
        .tx_adv     (tx_adv),
        .rx_adv     (rx_adv),
        .cmd_irq    (cmd_irq),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata)
    );

    // R5: an enabled transmit head only moves after a descriptor write two cycles earlier
    a_r5_wb_before_head: assert property (@(posedge clk) disable iff (rst)
        (r_en[0] && r_head[0] != $past(r_head[0])) |-> $past(mem_we, 2));

endmodule

// File: tb/sim_acq_ring_engine.sv
module sim_acq_ring_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [63:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        evt_valid = 1'b0;
    logic        evt_ready;
    logic [15:0] evt_opcode = '0;
    logic [31:0] evt_data = '0;
    logic        cmd_irq, rx_overflow;

    localparam logic [15:0] F_BUF = 16'h1000;
    localparam logic [15:0] F_LB  = 16'h0200;
    localparam logic [15:0] F_SI  = 16'h2000;

    logic [31:0] mem [0:1023];
    int n_chk = 0, n_fail = 0, irq_cnt = 0;
    int irq0, exp_irq, k, slot, cur_tail;
    logic [15:0] e_op [8];
    logic [15:0] e_fl [8];
    logic [15:0] e_len [8];
    int          e_slot [8];
    logic [31:0] v, ev_d [4];
    bit          err;

    acq_ring_engine u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .evt_valid(evt_valid), .evt_ready(evt_ready),
        .evt_opcode(evt_opcode), .evt_data(evt_data), .cmd_irq(cmd_irq),
        .rx_overflow(rx_overflow)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[9:0]];
        end
    end

    always @(negedge clk) if (!rst && cmd_irq) irq_cnt++;

    function automatic logic [31:0] exp_w0(input logic [15:0] op, input logic [15:0] fl, input bit e);
        return {op, fl | 16'h0003 | (e ? 16'h0004 : 16'h0000)};
    endfunction

    function automatic logic [31:0] exp_w1(input logic [15:0] len, input bit e);
        return {(e ? 16'd1 : 16'd0), len};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, expv);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_head(input logic [3:0] a, input int target, input string tag);
        logic [31:0] h;
        for (int i = 0; i < 600; i++) begin
            rd(a, h);
            if (h == target) return;
        end
        chk(1'b0, tag, h, target);
    endtask

    task automatic put_desc(input int w, input logic [15:0] op, input logic [15:0] fl,
                            input logic [15:0] len, input logic [31:0] ba);
        mem[w]   = {op, fl};
        mem[w+1] = {16'h0, len};
        mem[w+2] = ba;
        mem[w+3] = 32'h0;
    endtask

    task automatic inject(input logic [15:0] op, input logic [31:0] d);
        @(negedge clk);
        evt_valid = 1'b1; evt_opcode = op; evt_data = d;
        while (!evt_ready) @(negedge clk);
        @(negedge clk);
        evt_valid = 1'b0;
        repeat (14) @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h1C0FFEE5));
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int r = 0; r < 2; r++)
            for (int i = 0; i < 5; i++) begin
                rd(4'(r * 8 + i), v);
                chk(v == 0, "R1 reg reset", v, 0);
            end
        chk(evt_ready == 1'b1 && mem_req == 1'b0 && rx_overflow == 1'b0, "R1 idle outputs",
            {evt_ready, mem_req, rx_overflow}, 3'b100);

        // R2: head write ignored
        wr(4'h3, 32'd5);
        rd(4'h3, v);
        chk(v == 0, "R2 head write ignored", v, 0);

        // transmit ring: base 0, count 8
        wr(4'h0, 32'd0);
        wr(4'h2, 32'h8000_0008);
        rd(4'h2, v);
        chk(v == 32'h8000_0008, "R2 length readback", v, 32'h8000_0008);

        // R4 R5 R6 R8: direct command with interrupt flag, address must be ignored
        put_desc(0, 16'h0101, F_SI, 16'h0010, 32'd300);
        mem[300] = 32'hDEAD_BEEF;
        irq0 = irq_cnt;
        wr(4'h4, 32'd1);
        wait_head(4'h3, 1, "R4 direct completion");
        chk(mem[0] == exp_w0(16'h0101, F_SI, 0), "R5 direct w0", mem[0], exp_w0(16'h0101, F_SI, 0));
        chk(mem[1] == exp_w1(16'h0010, 0), "R5 direct w1", mem[1], exp_w1(16'h0010, 0));
        chk(mem[300] == 32'hDEAD_BEEF, "R6 direct buffer untouched", mem[300], 32'hDEAD_BEEF);
        chk(irq_cnt - irq0 == 1, "R8 one pulse", irq_cnt - irq0, 1);

        // R7: indirect with zero length
        put_desc(4, 16'h0202, F_BUF, 16'h0000, 32'd304);
        mem[304] = 32'h1111_1111;
        irq0 = irq_cnt;
        wr(4'h4, 32'd2);
        wait_head(4'h3, 2, "R7 completion");
        chk(mem[4] == exp_w0(16'h0202, F_BUF, 1), "R7 error flag", mem[4], exp_w0(16'h0202, F_BUF, 1));
        chk(mem[5] == exp_w1(16'h0000, 1), "R7 retval", mem[5], exp_w1(16'h0000, 1));
        chk(mem[304] == 32'h0202_0000, "R6 indirect buffer", mem[304], 32'h0202_0000);
        chk(irq_cnt == irq0, "R8 no pulse without flag", irq_cnt - irq0, 0);

        // R9 R3 R5 R6 R7 R8: random batches crossing the wrap
        cur_tail = 2;
        for (int rnd = 0; rnd < 14; rnd++) begin
            k = 1 + int'($urandom % 5);
            irq0 = irq_cnt;
            exp_irq = 0;
            for (int j = 0; j < k; j++) begin
                slot = (cur_tail + j) % 8;
                e_slot[j] = slot;
                e_op[j] = 16'($urandom);
                e_fl[j] = (16'($urandom) & 16'h00F0) | (($urandom % 2) ? F_BUF : 16'h0)
                          | (($urandom % 2) ? F_SI : 16'h0);
                e_len[j] = ($urandom % 3 == 0) ? 16'h0 : 16'($urandom);
                put_desc(slot * 4, e_op[j], e_fl[j], e_len[j], 32'(512 + slot * 4));
                mem[512 + slot * 4] = 32'hA5A5_0000 + 32'(rnd);
                if (e_fl[j][13]) exp_irq++;
            end
            cur_tail = (cur_tail + k) % 8;
            wr(4'h4, 32'(cur_tail));
            wait_head(4'h3, cur_tail, "R9 batch drained");
            rd(4'h3, v);
            chk(v < 8, "R3 head in range", v, 7);
            for (int j = 0; j < k; j++) begin
                err = e_fl[j][12] && (e_len[j] == 0);
                chk(mem[e_slot[j] * 4] == exp_w0(e_op[j], e_fl[j], err), "R5 batch w0",
                    mem[e_slot[j] * 4], exp_w0(e_op[j], e_fl[j], err));
                chk(mem[e_slot[j] * 4 + 1] == exp_w1(e_len[j], err), "R7 batch w1",
                    mem[e_slot[j] * 4 + 1], exp_w1(e_len[j], err));
                v = e_fl[j][12] ? {e_op[j], e_len[j]} : (32'hA5A5_0000 + 32'(rnd));
                chk(mem[512 + e_slot[j] * 4] == v, "R6 batch buffer", mem[512 + e_slot[j] * 4], v);
            end
            chk(irq_cnt - irq0 == exp_irq, "R8 batch pulses", irq_cnt - irq0, exp_irq);
        end

        // R12: disable resets head and halts processing
        wr(4'h2, 32'h0000_0008);
        rd(4'h3, v);
        chk(v == 0, "R12 head cleared", v, 0);
        for (int j = 0; j < 3; j++) put_desc(j * 4, 16'(16'h0700 + j), 16'h0, 16'd5, 32'd900);
        wr(4'h4, 32'd3);
        repeat (40) @(negedge clk);
        rd(4'h3, v);
        chk(v == 0, "R12 halted head", v, 0);
        chk(mem[0] == {16'h0700, 16'h0}, "R12 descriptor untouched", mem[0], {16'h0700, 16'h0});
        wr(4'h2, 32'h8000_0008);
        wait_head(4'h3, 3, "R12 resume");
        chk(mem[8] == exp_w0(16'h0702, 16'h0, 0), "R12 resumed w0", mem[8], exp_w0(16'h0702, 16'h0, 0));

        // receive ring: base 64, count 4, armed with tail 3
        for (int i = 0; i < 4; i++) begin
            put_desc(64 + i * 4, 16'h0, ((i == 1) ? 16'h0 : F_BUF) | ((i == 2) ? F_LB : 16'h0),
                     16'd64, 32'(700 + i * 4));
            mem[700 + i * 4] = 32'h5555_0000 + 32'(i);
        end
        wr(4'h8, 32'd64);
        wr(4'hA, 32'h8000_0004);
        wr(4'hC, 32'd3);
        for (int i = 0; i < 3; i++) begin
            ev_d[i] = $urandom;
            inject(16'(16'h0E00 + i), ev_d[i]);
        end
        rd(4'hB, v);
        chk(v == 3, "R13 head after armed events", v, 3);
        chk(rx_overflow == 1'b0, "R13 no overflow yet", rx_overflow, 0);
        for (int i = 0; i < 3; i++) begin
            logic [15:0] fl;
            fl = ((i == 1) ? 16'h0 : F_BUF) | ((i == 2) ? F_LB : 16'h0);
            chk(mem[64 + i * 4] == exp_w0(16'(16'h0E00 + i), fl, 0), "R10 event w0",
                mem[64 + i * 4], exp_w0(16'(16'h0E00 + i), fl, 0));
            chk(mem[65 + i * 4] == exp_w1(16'd64, 0), "R10 event w1 keeps size",
                mem[65 + i * 4], exp_w1(16'd64, 0));
            v = (i == 1) ? 32'h5555_0001 : ev_d[i];
            chk(mem[700 + i * 4] == v, "R10 event buffer", mem[700 + i * 4], v);
        end

        // R11 R13: full ring drops the event
        inject(16'h0E03, 32'hCAFE_F00D);
        chk(rx_overflow == 1'b1, "R11 overflow port", rx_overflow, 1);
        rd(4'hA, v);
        chk(v[30] == 1'b1, "R11 overflow bit", v, 32'hC000_0004);
        chk(mem[76] == {16'h0, F_BUF}, "R11 dropped no write", mem[76], {16'h0, F_BUF});
        rd(4'hB, v);
        chk(v == 3, "R11 head unchanged", v, 3);
        wr(4'hA, 32'h8000_0004);
        chk(rx_overflow == 1'b0, "R11 overflow cleared", rx_overflow, 0);

        // R10 R3: host returns two descriptors, head wraps
        wr(4'hC, 32'd1);
        inject(16'h0E04, 32'h0BAD_CAFE);
        rd(4'hB, v);
        chk(v == 0, "R3 rx head wrap", v, 0);
        chk(mem[76] == exp_w0(16'h0E04, F_BUF, 0), "R10 wrapped w0", mem[76], exp_w0(16'h0E04, F_BUF, 0));
        chk(mem[712] == 32'h0BAD_CAFE, "R10 wrapped buffer", mem[712], 32'h0BAD_CAFE);
        inject(16'h0E05, 32'h1234_5678);
        inject(16'h0E06, 32'h8765_4321);
        chk(rx_overflow == 1'b1, "R11 overflow after refill", rx_overflow, 1);
        rd(4'hB, v);
        chk(v == 1, "R10 head after refill", v, 1);

        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule